// File: doc/BRIEF.md
# Byte-Array Write Controller with Region Locking

This block manages writes to a 512-byte, 8-bit-wide non-volatile array behind a two-wire serial slave. The serial front end has already decoded the bus traffic. It delivers a start strobe that carries the target address, one strobe per received data byte, and a stop strobe that ends the transfer. The controller collects up to one page of 16 bytes in a local buffer. On the stop strobe it commits them to the array in one self-timed programming cycle, and `busy` stays high for the whole cycle.

Two mechanisms can refuse a write. A 3-bit lock setting protects a region at the top of the address space. A write-protect pin refuses every write when it is high, including a change to the lock setting. A low-supply inhibit input blocks new transfers and aborts a transfer that is still collecting bytes. A programming cycle that has already started is always allowed to finish. A synchronous read port with one cycle of latency lets the system, and the bench, see the array contents.

Top module: `wr_eeprom_ctrl`

## Requirements
- R1: After reset, `busy` and `req_nack` are low, `lock_code` is 0 and every array byte reads 8'hFF.
- R2: A single byte sent between a start and a stop is stored at the start address and can be read back once `busy` falls.
- R3: Within a transfer, data bytes go to consecutive addresses of the 16-byte page that holds the start address. The page offset wraps from 15 to 0, so the 17th byte overwrites the slot of the 1st.
- R4: `lock_code` protects a region at the top of the array. The codes are: 0 none, 1 the upper quarter (>=384), 2 the upper half (>=256), 3 the whole array, 4 the top 16 bytes (>=496), 5 the top 32 (>=480), 6 the top 64 (>=448), 7 the top 128 (>=384). Protected bytes of a page are left unchanged while the unprotected bytes of the same page are written.
- R5: While `wp_pin` is high, no array byte changes, and a `cfg_wr` is refused: `lock_code` stays unchanged and `req_nack` pulses in the next cycle.
- R6: While `supply_low` is high, a start strobe is refused with a `req_nack` pulse in the next cycle. A transfer that is still collecting bytes is dropped, and nothing is written. A programming cycle that is already running completes normally.
- R7: A stop strobe that commits at least one permitted byte raises `busy` in the next cycle. `busy` then stays high for exactly 16 + CYCLE_TICKS cycles.
- R8: While `busy` is high, a start strobe or a `cfg_wr` is refused with `req_nack` in the next cycle, and neither the array nor `lock_code` changes.
- R9: A stop strobe with no permitted byte to write does not start a programming cycle, and `busy` stays low.
- R10: `rd_data` presents the array byte at `rd_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_pin | input | 1 | Global write protect, high refuses all writes |
| supply_low | input | 1 | Low-supply inhibit |
| cmd_start | input | 1 | Start of a write transfer, one-cycle strobe |
| cmd_addr | input | 9 | Target byte address, valid with `cmd_start` |
| data_valid | input | 1 | One received data byte is present |
| data_byte | input | 8 | Received data byte |
| cmd_stop | input | 1 | End of transfer, requests the commit |
| cfg_wr | input | 1 | Request to load a new lock setting |
| cfg_lock | input | 3 | New lock setting |
| rd_addr | input | 9 | Read address |
| rd_data | output | 8 | Read data, one cycle of latency |
| busy | output | 1 | A programming cycle is running |
| req_nack | output | 1 | One-cycle pulse after a refused start or configuration request |
| lock_code | output | 3 | Current lock setting |

## Verification
A corrupted page offset or page base shows up as bytes landing at wrong addresses. That becomes visible at the read port as soon as `busy` falls after the faulty transfer. A wrong lock decode or a missed write-protect gate shows as changed bytes that should have held their value, again within one programming cycle. A wrong commit decision shows one cycle after the stop strobe, as `busy` rising or staying low against expectation. A slot or tick counter that is off by one shows as a `busy` window of the wrong length, measured on the same transfer.

// File: rtl/wr_eeprom_pkg.sv
// Shared types and the lock-region decode for the array write controller.
// Assumes the lock code is 3 bits wide and the protected regions lie at the top.
package wr_eeprom_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PROGRAM = 2'd2,
        ST_SETTLE  = 2'd3
    } wr_state_t;

    localparam int unsigned LOCK_W      = 3;
    localparam int unsigned SMALL_BLK_0 = 16;
    localparam int unsigned SMALL_BLK_1 = 32;
    localparam int unsigned SMALL_BLK_2 = 64;
    localparam int unsigned SMALL_BLK_3 = 128;

    // Number of bytes at the top of the array that a lock code protects.
    function automatic int unsigned lock_span(input logic [LOCK_W-1:0] code,
                                              input int unsigned depth);
        int unsigned span;
        case (code)
            3'd0:    span = 0;
            3'd1:    span = depth / 4;
            3'd2:    span = depth / 2;
            3'd3:    span = depth;
            3'd4:    span = SMALL_BLK_0;
            3'd5:    span = SMALL_BLK_1;
            3'd6:    span = SMALL_BLK_2;
            default: span = SMALL_BLK_3;
        endcase
        return span;
    endfunction

    // True when the address falls inside the region a lock code protects.
    function automatic logic lock_hit(input logic [LOCK_W-1:0] code,
                                      input int unsigned addr,
                                      input int unsigned depth);
        int unsigned span;
        span = lock_span(code, depth);
        return (span != 0) && (addr >= depth - span);
    endfunction

endpackage

// File: rtl/wr_lock_map.sv
// Produces one protection flag per slot of the current page.
// Assumes PAGE divides DEPTH; purely combinational.
module wr_lock_map #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned PAGE  = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned OFFW = $clog2(PAGE),
    localparam int unsigned PW   = AW - OFFW
) (
    input  logic [wr_eeprom_pkg::LOCK_W-1:0] lock_code,
    input  logic [PW-1:0]                    page_base,
    output logic [PAGE-1:0]                  prot_mask
);
    import wr_eeprom_pkg::*;

    for (genvar i = 0; i < PAGE; i++) begin : g_slot
        logic [AW-1:0] slot_addr;
        assign slot_addr = {page_base, OFFW'(i)};
        // Decode the protection of one page slot.
        always_comb prot_mask[i] = lock_hit(lock_code, 32'(slot_addr), DEPTH);
    end

endmodule

// File: rtl/wr_page_buf.sv
// Page staging buffer: one byte and one valid flag per slot.
// Assumes clear and write never coincide (the controller gives clear priority).
module wr_page_buf #(
    parameter int unsigned PAGE = 16,
    parameter int unsigned DW   = 8,
    localparam int unsigned OFFW = $clog2(PAGE)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr_en,
    input  logic [OFFW-1:0] wr_off,
    input  logic [DW-1:0]   wr_data,
    input  logic [OFFW-1:0] rd_off,
    output logic [DW-1:0]   rd_data,
    output logic [PAGE-1:0] valid_mask
);
    logic [DW-1:0]   slot_q [PAGE];
    logic [PAGE-1:0] valid_q;

    // Track which slots received data in the current transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_off] <= 1'b1;
        end
    end

    // Store received bytes; content is qualified by the valid flags.
    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            slot_q[wr_off] <= wr_data;
        end
    end

    assign rd_data    = slot_q[rd_off];
    assign valid_mask = valid_q;

endmodule

// File: rtl/wr_cycle_timer.sv
// Counts the settle portion of the self-timed programming cycle.
// Assumes TICKS >= 1; done pulses in the last counted cycle.
module wr_cycle_timer #(
    parameter int unsigned TICKS = 625000,
    localparam int unsigned CW   = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    logic [CW-1:0] cnt_q;
    logic          run_q;

    // Run from a start pulse until TICKS cycles have elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (done) begin
                run_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done = run_q && (cnt_q == CW'(TICKS - 1));

endmodule

// File: rtl/wr_mem_array.sv
// Behavioural byte array with one write port and a registered read port.
// Assumes a reset that returns every byte to the erased value 8'hFF.
module wr_mem_array #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cell_q [DEPTH];

    // Erase on reset, otherwise write one byte when requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                cell_q[i] <= '1;
            end
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    // Registered read of the addressed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '1;
        end else begin
            rdata <= cell_q[raddr];
        end
    end

endmodule

// File: rtl/wr_eeprom_ctrl.sv
// Write controller for a byte array behind a serial slave front end.
// Collects one page of bytes, applies the lock region, the write-protect pin
// and the low-supply inhibit, then commits in a self-timed cycle.
// Assumes the strobes are single-cycle pulses from an already parsed bus.
module wr_eeprom_ctrl #(
    parameter int unsigned DEPTH       = 512,
    parameter int unsigned DW          = 8,
    parameter int unsigned PAGE        = 16,
    parameter int unsigned CYCLE_TICKS = 625000,
    localparam int unsigned AW         = $clog2(DEPTH),
    localparam int unsigned OFFW       = $clog2(PAGE),
    localparam int unsigned PW         = AW - OFFW
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wp_pin,
    input  logic                             supply_low,
    input  logic                             cmd_start,
    input  logic [AW-1:0]                    cmd_addr,
    input  logic                             data_valid,
    input  logic [DW-1:0]                    data_byte,
    input  logic                             cmd_stop,
    input  logic                             cfg_wr,
    input  logic [wr_eeprom_pkg::LOCK_W-1:0] cfg_lock,
    input  logic [AW-1:0]                    rd_addr,
    output logic [DW-1:0]                    rd_data,
    output logic                             busy,
    output logic                             req_nack,
    output logic [wr_eeprom_pkg::LOCK_W-1:0] lock_code
);
    import wr_eeprom_pkg::*;

    wr_state_t         state_q;
    logic [PW-1:0]     page_q;
    logic [OFFW-1:0]   off_q;
    logic [OFFW-1:0]   slot_q;
    logic [LOCK_W-1:0] lock_q;
    logic              nack_q;

    logic [PAGE-1:0]   prot_mask;
    logic [PAGE-1:0]   valid_mask;
    logic [PAGE-1:0]   allow_mask;
    logic [DW-1:0]     slot_byte;

    logic              in_cycle;
    logic              start_ok;
    logic              cfg_ok;
    logic              refuse;
    logic              buf_clr;
    logic              buf_wr;
    logic              commit_ok;
    logic              timer_start;
    logic              timer_done;

    logic              mem_we;
    logic [AW-1:0]     mem_waddr;

    // Decide which requests are accepted this cycle.
    always_comb begin
        in_cycle    = (state_q == ST_PROGRAM) || (state_q == ST_SETTLE);
        allow_mask  = valid_mask & ~prot_mask;
        start_ok    = cmd_start && !supply_low && !in_cycle;
        cfg_ok      = cfg_wr && !cmd_start && (state_q == ST_IDLE)
                      && !wp_pin && !supply_low;
        refuse      = (cmd_start && !start_ok) || (cfg_wr && !cmd_start && !cfg_ok);
        buf_clr     = start_ok;
        buf_wr      = (state_q == ST_COLLECT) && !supply_low && !cmd_start
                      && !cmd_stop && data_valid;
        commit_ok   = (state_q == ST_COLLECT) && !supply_low && !cmd_start
                      && cmd_stop && !wp_pin && (|allow_mask);
        timer_start = (state_q == ST_PROGRAM) && (slot_q == OFFW'(PAGE - 1));
    end

    // Transfer sequencing: collect, program each slot, then settle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            page_q  <= '0;
            off_q   <= '0;
            slot_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        state_q <= ST_COLLECT;
                        page_q  <= cmd_addr[AW-1:OFFW];
                        off_q   <= cmd_addr[OFFW-1:0];
                    end
                end
                ST_COLLECT: begin
                    if (supply_low) begin
                        state_q <= ST_IDLE;
                    end else if (cmd_start) begin
                        page_q <= cmd_addr[AW-1:OFFW];
                        off_q  <= cmd_addr[OFFW-1:0];
                    end else if (cmd_stop) begin
                        state_q <= commit_ok ? ST_PROGRAM : ST_IDLE;
                        slot_q  <= '0;
                    end else if (data_valid) begin
                        off_q <= off_q + 1'b1;
                    end
                end
                ST_PROGRAM: begin
                    slot_q <= slot_q + 1'b1;
                    if (timer_start) begin
                        state_q <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (timer_done) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Hold the lock setting; only an accepted configuration request changes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else if (cfg_ok) begin
            lock_q <= cfg_lock;
        end
    end

    // One-cycle refusal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nack_q <= 1'b0;
        end else begin
            nack_q <= refuse;
        end
    end

    // Array write port: one slot per cycle, gated by lock and write protect.
    always_comb begin
        mem_we    = (state_q == ST_PROGRAM) && allow_mask[slot_q] && !wp_pin;
        mem_waddr = {page_q, slot_q};
    end

    wr_lock_map #(
        .DEPTH     (DEPTH),
        .PAGE      (PAGE)
    ) u_lock (
        .lock_code (lock_q),
        .page_base (page_q),
        .prot_mask (prot_mask)
    );

    wr_page_buf #(
        .PAGE       (PAGE),
        .DW         (DW)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (buf_clr),
        .wr_en      (buf_wr),
        .wr_off     (off_q),
        .wr_data    (data_byte),
        .rd_off     (slot_q),
        .rd_data    (slot_byte),
        .valid_mask (valid_mask)
    );

    wr_cycle_timer #(
        .TICKS (CYCLE_TICKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (timer_start),
        .done  (timer_done)
    );

    wr_mem_array #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (slot_byte),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign busy      = in_cycle;
    assign req_nack  = nack_q;
    assign lock_code = lock_q;

endmodule

// File: rtl/wr_eeprom_chk.sv
// Property checker for the write controller, attached by bind.
// Assumes the array write strobe and address are visible inside the top.
module wr_eeprom_chk #(
    parameter int unsigned DEPTH       = 512,
    parameter int unsigned PAGE        = 16,
    parameter int unsigned CYCLE_TICKS = 625000,
    localparam int unsigned AW         = $clog2(DEPTH)
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             wp_pin,
    input logic                             supply_low,
    input logic                             cmd_start,
    input logic                             cmd_stop,
    input logic                             busy,
    input logic                             req_nack,
    input logic [wr_eeprom_pkg::LOCK_W-1:0] lock_code,
    input logic                             mem_we,
    input logic [AW-1:0]                    mem_waddr
);
    import wr_eeprom_pkg::*;

    int unsigned busy_len_q;

    // Count consecutive busy cycles to check the window length.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            busy_len_q <= 0;
        end else begin
            busy_len_q <= busy_len_q + 1;
        end
    end

    // R1: first cycle out of reset is quiet
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!busy && !req_nack && lock_code == '0));

    // R2: the array is written only during a programming cycle
    a_r2_write_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R4: no write lands inside the locked region
    a_r4_no_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !lock_hit(lock_code, 32'(mem_waddr), DEPTH));

    // R5: write protect blocks every array write
    a_r5_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        wp_pin |-> !mem_we);

    // R6: a start under low supply is refused
    a_r6_low_start_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_low && cmd_start && !busy) |=> req_nack);

    // R7: busy only follows a stop strobe
    a_r7_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_stop));

    // R7: busy window has the fixed length
    a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len_q == PAGE + CYCLE_TICKS));

    // R8: a start during a cycle is refused and the lock holds
    a_r8_busy_start_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_start) |=> (req_nack && $stable(lock_code)));

endmodule

bind wr_eeprom_ctrl wr_eeprom_chk #(
    .DEPTH       (DEPTH),
    .PAGE        (PAGE),
    .CYCLE_TICKS (CYCLE_TICKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_pin     (wp_pin),
    .supply_low (supply_low),
    .cmd_start  (cmd_start),
    .cmd_stop   (cmd_stop),
    .busy       (busy),
    .req_nack   (req_nack),
    .lock_code  (lock_code),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr)
);

// File: tb/sim_wr_eeprom_ctrl.sv
module sim_wr_eeprom_ctrl;
    localparam int DEPTH = 512;
    localparam int PAGE  = 16;
    localparam int TICKS = 40;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       wp_pin = 0;
    logic       supply_low = 0;
    logic       cmd_start = 0;
    logic [8:0] cmd_addr = '0;
    logic       data_valid = 0;
    logic [7:0] data_byte = '0;
    logic       cmd_stop = 0;
    logic       cfg_wr = 0;
    logic [2:0] cfg_lock = '0;
    logic [8:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy;
    logic       req_nack;
    logic [2:0] lock_code;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;
    logic [7:0] mdl [DEPTH];
    int cur_lock = 0;

    always #4 clk = ~clk;

    wr_eeprom_ctrl #(.DEPTH(DEPTH), .DW(8), .PAGE(PAGE), .CYCLE_TICKS(TICKS)) u0 (
        .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .supply_low(supply_low),
        .cmd_start(cmd_start), .cmd_addr(cmd_addr), .data_valid(data_valid),
        .data_byte(data_byte), .cmd_stop(cmd_stop), .cfg_wr(cfg_wr),
        .cfg_lock(cfg_lock), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .req_nack(req_nack), .lock_code(lock_code)
    );

    function automatic bit exp_locked(input int code, input int a);
        case (code)
            0: return 0;
            1: return a >= 384;
            2: return a >= 256;
            3: return 1;
            4: return a >= 496;
            5: return a >= 480;
            6: return a >= 448;
            default: return a >= 384;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_start(input int a);
        @(negedge clk); cmd_start = 1; cmd_addr = 9'(a);
        @(negedge clk); cmd_start = 0;
    endtask

    task automatic do_byte(input logic [7:0] b);
        @(negedge clk); data_valid = 1; data_byte = b;
        @(negedge clk); data_valid = 0;
    endtask

    task automatic do_stop();
        @(negedge clk); cmd_stop = 1;
        @(negedge clk); cmd_stop = 0;
    endtask

    task automatic do_cfg(input int code);
        @(negedge clk); cfg_wr = 1; cfg_lock = 3'(code);
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        @(negedge clk); rd_addr = 9'(a);
        @(negedge clk); v = rd_data;
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        while (busy && cnt < 10000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic check_page(input int base, input string req);
        logic [7:0] v;
        for (int i = 0; i < PAGE; i++) begin
            rd(base + i, v);
            chk(v === mdl[base + i], req, v, mdl[base + i]);
        end
    endtask

    // Full transfer with model update; expected commit derived from rules.
    task automatic page_write(input int a, input int n, input string req);
        logic [7:0] pb [PAGE];
        bit pv [PAGE];
        int off, base, cnt;
        bit any;
        base = a & ~(PAGE - 1);
        off = a & (PAGE - 1);
        for (int i = 0; i < PAGE; i++) pv[i] = 0;
        do_start(a);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            pb[off] = b; pv[off] = 1;
            do_byte(b);
            off = (off + 1) % PAGE;
        end
        any = 0;
        for (int i = 0; i < PAGE; i++)
            if (pv[i] && !exp_locked(cur_lock, base + i)) any = 1;
        any = any && !wp_pin;
        do_stop();
        if (any) begin
            chk(busy === 1'b1, "R7 busy after stop", busy, 1);
            wait_idle(cnt);
            chk(cnt == PAGE + TICKS, "R7 busy length", cnt, PAGE + TICKS);
            for (int i = 0; i < PAGE; i++)
                if (pv[i] && !exp_locked(cur_lock, base + i)) mdl[base + i] = pb[i];
        end else begin
            chk(busy === 1'b0, "R9 no cycle", busy, 0);
        end
        check_page(base, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int cnt;
        void'($urandom(32'h1234_abcd));
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(req_nack === 1'b0, "R1 nack", req_nack, 0);
        chk(lock_code === 3'd0, "R1 lock", lock_code, 0);
        rd(0, v);   chk(v === 8'hFF, "R1 R10 erased 0", v, 8'hFF);
        rd(511, v); chk(v === 8'hFF, "R1 R10 erased 511", v, 8'hFF);

        // R2 single byte
        page_write(5, 1, "R2 single byte");
        // R3 wrap: 20 bytes from offset 8 of page 3
        page_write(9'h38, 20, "R3 page wrap");
        page_write(9'h100, 16, "R3 full page");

        // R4 lock codes with pages on region edges
        do_cfg(4); cur_lock = 4;
        chk(lock_code === 3'd4, "R4 lock load", lock_code, 4);
        page_write(9'h1F0, 16, "R4 top16 locked");
        page_write(9'h1E0, 16, "R4 below top16");
        do_cfg(2); cur_lock = 2;
        page_write(9'h0F8, 16, "R4 half edge");
        page_write(9'h100, 4, "R4 half locked");
        do_cfg(3); cur_lock = 3;
        page_write(9'h000, 8, "R4 all locked");
        do_cfg(0); cur_lock = 0;

        // R5 write protect
        wp_pin = 1;
        do_cfg(6);
        chk(req_nack === 1'b1, "R5 cfg nack", req_nack, 1);
        chk(lock_code === 3'd0, "R5 lock kept", lock_code, 0);
        page_write(9'h040, 16, "R5 wp page unchanged");
        wp_pin = 0;

        // R6 low supply
        supply_low = 1;
        do_start(9'h080);
        chk(req_nack === 1'b1, "R6 start nack", req_nack, 1);
        supply_low = 0;
        do_start(9'h080);
        do_byte(8'h11); do_byte(8'h22);
        @(negedge clk); supply_low = 1;
        @(negedge clk); supply_low = 0;
        do_stop();
        chk(busy === 1'b0, "R6 aborted no cycle", busy, 0);
        check_page(9'h080, "R6 abort unchanged");
        do_start(9'h090);
        do_byte(8'h5A);
        do_stop();
        mdl[9'h090] = 8'h5A;
        supply_low = 1;
        wait_idle(cnt);
        chk(cnt == PAGE + TICKS, "R6 cycle completes", cnt, PAGE + TICKS);
        supply_low = 0;
        check_page(9'h090, "R6 completed write");

        // R8 requests during busy
        do_start(9'h0A0);
        do_byte(8'h77);
        do_stop();
        mdl[9'h0A0] = 8'h77;
        do_start(9'h0B0);
        chk(req_nack === 1'b1, "R8 start nack", req_nack, 1);
        do_cfg(5);
        chk(req_nack === 1'b1, "R8 cfg nack", req_nack, 1);
        chk(lock_code === 3'd0, "R8 lock kept", lock_code, 0);
        wait_idle(cnt);
        check_page(9'h0A0, "R8 data");
        check_page(9'h0B0, "R8 untouched");

        // Constrained random transfers
        for (int it = 0; it < 40; it++) begin
            if ($urandom_range(3) == 0) begin
                int c;
                c = int'($urandom_range(7));
                do_cfg(c);
                cur_lock = c;
                chk(lock_code === 3'(c), "R4 random lock", lock_code, c);
            end
            wp_pin = ($urandom_range(9) == 0);
            page_write(int'($urandom_range(DEPTH - 1)), int'($urandom_range(20, 1)),
                       wp_pin ? "R5 random" : "R4 random");
            wp_pin = 0;
        end

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule